// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit sits between instruction decode and the load/store path of a small 16-bit datapath. For each request it is handed a 4-bit addressing-mode code, the address/displacement field of the instruction, a flag telling whether that field is a narrow 8-bit or a full 16-bit value, the contents of the register that decode named (through a register-file read port), and the current program counter. It returns one of three things: an effective address, an immediate operand, or, for register mode, nothing beyond completion. For the two pointer-update modes it also returns the new pointer value as a register write-back request, in the same cycle as the address.

Ten modes are supported. Memory-indirect mode is the only one that uses the unit's own memory port. It issues a single read at the field address and takes the word returned as the effective address. The memory answers one cycle after a request. All address arithmetic runs through one shared 16-bit adder/subtractor and wraps modulo 2^16 with no error report.

The controller is a three-state machine. IDLE accepts a request. A memory-indirect request moves IDLE to PTR_REQ, where the read is issued. PTR_REQ always moves on to PTR_WAIT, where the returned word is captured. PTR_WAIT always returns to IDLE. Every other mode completes from IDLE and stays in IDLE.

Top module: `ea_unit`

## Requirements
- R1: After reset, done, ea_valid, imm_valid, wb_en, illegal_mode and mem_req are all low.
- R2: Mode code 1 (immediate) completes one cycle after start is sampled with imm_valid high, imm_value equal to the extended field, ea_valid low and no memory request.
- R3: Mode code 2 (direct) gives ea equal to the whole 16-bit field, and mode code 5 (indexed) gives ea equal to the whole field plus the register value. Both complete one cycle after start.
- R4: Mode code 3 (register-indirect) gives ea equal to the register value. Mode code 0 (register) completes one cycle after start with ea_valid, imm_valid, wb_en and illegal_mode all low.
- R5: Mode code 4 (memory-indirect) raises mem_req for exactly one cycle with mem_addr equal to the whole field. done arrives three cycles after start is sampled, with ea equal to the word the memory returned.
- R6: Mode code 6 (auto-increment) gives ea equal to the register value. In the same done cycle it asserts wb_en with wb_data equal to the register value plus the element size.
- R7: Mode code 7 (auto-decrement) asserts wb_en and gives both ea and wb_data equal to the register value minus the element size.
- R8: The element size select maps 0 to 1 byte, 1 to 2 bytes, and both 2 and 3 to 4 bytes.
- R9: Mode code 8 (PC-relative) gives ea = pc + displacement, and mode code 9 (base) gives ea = register + displacement. The displacement (and the immediate value) is the field itself when field_wide is 1, and bits 7:0 of the field sign-extended when field_wide is 0.
- R10: Address sums and differences wrap modulo 2^16 and never raise illegal_mode.
- R11: Mode codes 10 to 15 complete one cycle after start with illegal_mode high and with ea_valid, imm_valid, wb_en and mem_req low.
- R12: A start presented while a memory-indirect request is in PTR_REQ or PTR_WAIT is ignored. That request produces exactly one done.
- R13: wb_en, imm_valid and illegal_mode are only ever high together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled in IDLE |
| mode | input | 4 | Addressing-mode code |
| field | input | 16 | Instruction address/displacement field |
| field_wide | input | 1 | 1: field is 16 bits; 0: low 8 bits, sign-extended |
| size_sel | input | 2 | Element size select for pointer update |
| reg_rdata | input | 16 | Contents of the named register |
| pc | input | 16 | Current program counter |
| mem_req | output | 1 | Memory read request (memory-indirect only) |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, valid the cycle after mem_req |
| done | output | 1 | Completion strobe |
| ea_valid | output | 1 | ea carries an effective address |
| ea | output | 16 | Effective address |
| imm_valid | output | 1 | imm_value carries an immediate operand |
| imm_value | output | 16 | Immediate operand |
| wb_en | output | 1 | Pointer write-back request |
| wb_data | output | 16 | Updated pointer value |
| illegal_mode | output | 1 | Unused mode code was requested |

## Verification
In the pointer-update modes, the effective address and the register write-back both land in the single done cycle, and one mode uses the old pointer while the other uses the new one. The bench sweeps every mode code against every size select, both field widths and register values near zero and near the top of the range. At the done sample it compares ea and wb_data together against sums computed in the bench, which also covers wrap-around. A second overlap is a new start arriving while a memory-indirect read is still in flight. This is provoked by holding start high across PTR_REQ and PTR_WAIT. The bench then expects one done, carrying the indirect result, and no done in the cycle after it.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam logic [3:0] MD_REG   = 4'd0;
    localparam logic [3:0] MD_IMM   = 4'd1;
    localparam logic [3:0] MD_DIR   = 4'd2;
    localparam logic [3:0] MD_RIND  = 4'd3;
    localparam logic [3:0] MD_MIND  = 4'd4;
    localparam logic [3:0] MD_IDX   = 4'd5;
    localparam logic [3:0] MD_AINC  = 4'd6;
    localparam logic [3:0] MD_ADEC  = 4'd7;
    localparam logic [3:0] MD_PCREL = 4'd8;
    localparam logic [3:0] MD_BASE  = 4'd9;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PTR_REQ  = 2'd1,
        ST_PTR_WAIT = 2'd2
    } ea_state_e;

endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
    parameter int AW = 16,
    parameter int NW = 8
) (
    input  logic [AW-1:0] raw,
    input  logic          wide,
    output logic [AW-1:0] ext
);
    localparam int PADW = AW - NW;

    generate
        if (PADW > 0) begin : g_pad
            assign ext = wide ? raw : {{PADW{raw[NW-1]}}, raw[NW-1:0]};
        end else begin : g_nopad
            assign ext = raw;
        end
    endgenerate
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] field,
    input  logic [AW-1:0] disp,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] pc,
    input  logic [1:0]    size_sel,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] wb_data,
    output logic [AW-1:0] imm_value,
    output logic          ea_valid,
    output logic          imm_valid,
    output logic          wb_en,
    output logic          illegal,
    output logic          indirect
);
    logic [AW-1:0] a_op, b_op, step, sum;
    logic          sub;

    always_comb begin
        unique case (size_sel)
            2'd0:    step = AW'(1);
            2'd1:    step = AW'(2);
            default: step = AW'(4);
        endcase
    end

    always_comb begin
        a_op      = base;
        b_op      = '0;
        sub       = 1'b0;
        ea_valid  = 1'b1;
        imm_valid = 1'b0;
        wb_en     = 1'b0;
        illegal   = 1'b0;
        indirect  = 1'b0;
        case (mode)
            MD_REG:   ea_valid = 1'b0;
            MD_IMM:   begin ea_valid = 1'b0; imm_valid = 1'b1; end
            MD_DIR:   a_op = field;
            MD_RIND:  ;
            MD_MIND:  begin ea_valid = 1'b0; indirect = 1'b1; end
            MD_IDX:   begin a_op = field; b_op = base; end
            MD_AINC:  begin b_op = step; wb_en = 1'b1; end
            MD_ADEC:  begin b_op = step; sub = 1'b1; wb_en = 1'b1; end
            MD_PCREL: begin a_op = pc; b_op = disp; end
            MD_BASE:  b_op = disp;
            default:  begin ea_valid = 1'b0; illegal = 1'b1; end
        endcase
    end

    // one shared adder/subtractor, wraps modulo 2^AW
    assign sum       = sub ? (a_op - b_op) : (a_op + b_op);
    assign ea        = (mode == MD_AINC) ? base : sum;
    assign wb_data   = sum;
    assign imm_value = disp;
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] field,
    input  logic          field_wide,
    input  logic [1:0]    size_sel,
    input  logic [AW-1:0] reg_rdata,
    input  logic [AW-1:0] pc,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic          ea_valid,
    output logic [AW-1:0] ea,
    output logic          imm_valid,
    output logic [AW-1:0] imm_value,
    output logic          wb_en,
    output logic [AW-1:0] wb_data,
    output logic          illegal_mode
);
    ea_state_e     state, nxt;
    logic [AW-1:0] disp, ptr_q;
    logic [AW-1:0] c_ea, c_wb, c_imm;
    logic          c_eav, c_immv, c_wben, c_ill, c_ind;
    logic          accept;

    ea_sext #(.AW(AW), .NW(NW)) u_sext (
        .raw(field), .wide(field_wide), .ext(disp)
    );

    ea_calc #(.AW(AW)) u_calc (
        .mode(mode), .field(field), .disp(disp), .base(reg_rdata), .pc(pc),
        .size_sel(size_sel), .ea(c_ea), .wb_data(c_wb), .imm_value(c_imm),
        .ea_valid(c_eav), .imm_valid(c_immv), .wb_en(c_wben),
        .illegal(c_ill), .indirect(c_ind)
    );

    assign accept   = (state == ST_IDLE) && start;
    assign mem_req  = (state == ST_PTR_REQ);
    assign mem_addr = ptr_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start && c_ind) nxt = ST_PTR_REQ;
            ST_PTR_REQ:  nxt = ST_PTR_WAIT;
            ST_PTR_WAIT: nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr_q <= '0;
        end else begin
            state <= nxt;
            if (accept && c_ind) ptr_q <= field;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done         <= 1'b0;
            ea_valid     <= 1'b0;
            imm_valid    <= 1'b0;
            wb_en        <= 1'b0;
            illegal_mode <= 1'b0;
            ea           <= '0;
            imm_value    <= '0;
            wb_data      <= '0;
        end else begin
            done         <= 1'b0;
            ea_valid     <= 1'b0;
            imm_valid    <= 1'b0;
            wb_en        <= 1'b0;
            illegal_mode <= 1'b0;
            if (accept && !c_ind) begin
                done         <= 1'b1;
                ea_valid     <= c_eav;
                imm_valid    <= c_immv;
                wb_en        <= c_wben;
                illegal_mode <= c_ill;
                ea           <= c_ea;
                imm_value    <= c_imm;
                wb_data      <= c_wb;
            end else if (state == ST_PTR_WAIT) begin
                done     <= 1'b1;
                ea_valid <= 1'b1;
                ea       <= mem_rdata;
            end
        end
    end

    // R5: a read request lasts one cycle, and the result follows two cycles on
    assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (!mem_req && !done));
    assert_req_then_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> ##1 (done && ea_valid));
    // R13: side flags only accompany completion
    assert_wb_with_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (done && ea_valid));
    assert_imm_with_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        imm_valid |-> (done && !ea_valid && !wb_en));
    // R11: illegal codes produce no address, write-back or memory traffic
    assert_illegal_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_mode |-> (done && !ea_valid && !wb_en && !imm_valid && !mem_req));
    // R12: no completion can start while a pointer read is in flight
    assert_busy_no_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTR_REQ) |=> !done);
endmodule

// File: tb/ea_unit_test.sv
module ea_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] field = '0;
    logic        field_wide = 1'b0;
    logic [1:0]  size_sel = '0;
    logic [15:0] reg_rdata = '0;
    logic [15:0] pc = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        done, ea_valid, imm_valid, wb_en, illegal_mode;
    logic [15:0] ea, imm_value, wb_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int req_cnt = 0;
    logic [15:0] req_addr = '0;

    always #4 clk = ~clk;  // 125 MHz

    ea_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
        .field_wide(field_wide), .size_sel(size_sel), .reg_rdata(reg_rdata),
        .pc(pc), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .ea_valid(ea_valid), .ea(ea), .imm_valid(imm_valid),
        .imm_value(imm_value), .wb_en(wb_en), .wb_data(wb_data),
        .illegal_mode(illegal_mode)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'hA5C3;
    endfunction

    // memory model: data one cycle after request
    always @(posedge clk) begin
        if (mem_req) begin
            mem_rdata <= mem_word(mem_addr);
            req_cnt   <= req_cnt + 1;
            req_addr  <= mem_addr;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ext16(input logic [15:0] f, input logic w);
        return w ? f : {{8{f[7]}}, f[7:0]};
    endfunction

    function automatic logic [15:0] stepv(input logic [1:0] s);
        return (s == 2'd0) ? 16'd1 : (s == 2'd1) ? 16'd2 : 16'd4;
    endfunction

    task automatic run_op(input logic [3:0] m, input logic [15:0] f,
                          input logic w, input logic [1:0] s,
                          input logic [15:0] r, input logic [15:0] p);
        int lat;
        int rc0;
        logic [15:0] d;
        logic [15:0] xea;
        d = ext16(f, w);
        @(negedge clk);
        mode = m; field = f; field_wide = w; size_sel = s;
        reg_rdata = r; pc = p; start = 1'b1;
        rc0 = req_cnt;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        case (m)
            4'd0: begin
                check(lat == 1, "R4 reg latency", lat, 1);
                check(!ea_valid && !imm_valid && !wb_en && !illegal_mode,
                      "R4 reg flags", {ea_valid, imm_valid, wb_en, illegal_mode}, 0);
            end
            4'd1: begin
                check(lat == 1 && imm_valid && !ea_valid, "R2 imm flags",
                      {lat[7:0], imm_valid, ea_valid}, {8'd1, 2'b10});
                check(imm_value == d, "R2 R9 imm value", imm_value, d);
            end
            4'd4: begin
                check(lat == 3, "R5 latency", lat, 3);
                check(req_cnt - rc0 == 1 && req_addr == f, "R5 request",
                      {req_cnt - rc0, req_addr}, {16'd1, f});
                check(ea_valid && ea == mem_word(f), "R5 ea", ea, mem_word(f));
            end
            4'd6: begin
                xea = r + stepv(s);
                check(ea_valid && ea == r, "R6 ea", ea, r);
                check(wb_en && wb_data == xea, "R6 R8 R10 writeback", wb_data, xea);
            end
            4'd7: begin
                xea = r - stepv(s);
                check(ea_valid && ea == xea, "R7 R10 ea", ea, xea);
                check(wb_en && wb_data == xea, "R7 R8 writeback", wb_data, xea);
            end
            4'd2, 4'd3, 4'd5, 4'd8, 4'd9: begin
                case (m)
                    4'd2: xea = f;
                    4'd3: xea = r;
                    4'd5: xea = f + r;
                    4'd8: xea = p + d;
                    default: xea = r + d;
                endcase
                check(lat == 1 && ea_valid && !wb_en && !illegal_mode,
                      "R3 R4 R9 R10 flags", {lat[7:0], ea_valid, wb_en, illegal_mode},
                      {8'd1, 3'b100});
                check(ea == xea, "R3 R4 R9 R10 ea", ea, xea);
            end
            default: begin
                check(lat == 1 && illegal_mode && !ea_valid && !wb_en && !imm_valid,
                      "R11 illegal", {lat[7:0], illegal_mode, ea_valid, wb_en, imm_valid},
                      {8'd1, 4'b1000});
            end
        endcase
        if (m != 4'd4)
            check(req_cnt == rc0, "R2 R11 no memory", req_cnt - rc0, 0);
        @(negedge clk);
        check(!done, "R13 single done", done, 0);
    endtask

    initial begin
        logic [15:0] fields [7];
        logic [15:0] regs [4];
        fields = '{16'h0000, 16'h007F, 16'h0080, 16'h00FF, 16'h7FF0, 16'hFF80, 16'h8001};
        regs   = '{16'h0000, 16'h0001, 16'hFFFE, 16'h1234};
        repeat (3) @(negedge clk);
        check(!done && !ea_valid && !imm_valid && !wb_en && !illegal_mode && !mem_req,
              "R1 reset", {done, ea_valid, imm_valid, wb_en, illegal_mode, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !mem_req, "R1 after release", {done, mem_req}, 0);

        for (int m = 0; m < 16; m++)
            for (int fi = 0; fi < 7; fi++)
                for (int ri = 0; ri < 4; ri++)
                    for (int w = 0; w < 2; w++)
                        for (int s = 0; s < 4; s++)
                            run_op(4'(m), fields[fi], w[0], 2'(s), regs[ri],
                                   16'hFFF0 + 16'(fi * 3));

        // R12: start held high while a pointer read is in flight
        @(negedge clk);
        mode = 4'd4; field = 16'h0040; field_wide = 1'b1; start = 1'b1;
        @(negedge clk);
        mode = 4'd2; field = 16'h1111;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        check(done && ea == mem_word(16'h0040), "R12 busy result", ea, mem_word(16'h0040));
        @(negedge clk);
        check(!done, "R12 busy start ignored", done, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule